// File: doc/BRIEF.md
# Latched 64-bit free-running counter

This peripheral keeps a 64-bit count that goes up by one on every clock edge after reset. It never stops and never reloads. A 32-bit register bus cannot read a 64-bit value in one access, so software asks for a snapshot first. It sets a request bit in the control register, waits until the hardware clears that bit, and then reads the two 32-bit halves of a snapshot register. Both halves are copied from the live count on the same edge, so together they always form one coherent value.

The same control register holds a clear bit, which returns the count to zero. Both bits clear themselves. Between operations the control register therefore reads back the same value it held before. The bus has an address, a write enable with write data, and a read enable. Each read returns its data with a valid strobe one cycle later.

Top module: `snap_counter64`

## Requirements
- R1: While reset is held and right after it is released, the count, the control register and both snapshot words are all zero.
- R2: Outside a clear, the count goes up by exactly one on every clock edge and wraps modulo 2^64.
- R3: The register map is fixed. Control is at 0xA0, with bit 0 = clear and bit 1 = latch request. The low snapshot word (count bits 31:0) is at 0xA4. The high snapshot word (count bits 63:32) is at 0xA8.
- R4: A read sampled on edge N drives rd_valid high and presents rd_data after edge N, for one cycle. rd_valid is never high without a read.
- R5: A control write with bit 0 = 1 zeroes the count on its own edge. Bit 0 then reads 1 for exactly one cycle and clears itself.
- R6: A control write with bit 1 = 1 on edge E requests a snapshot of the count value held just after E. Both snapshot words take that value together on edge E+2. Bit 1 reads 1 for reads sampled on E+1 and E+2, and reads 0 from E+3 on.
- R7: Once a latch completes, the control register reads back the value it held before the request (zero after initialisation).
- R8: A control write with both bits set clears the count first and then latches it, so both snapshot words read zero.
- R9: A latch request that arrives while one is pending merges with it. The pending snapshot keeps its value and its completion edge.
- R10: Writes to 0xA4 and 0xA8 are ignored. Control bits 31:2 read zero and their written values have no effect. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle strobe marking returned read data |

## Verification
Every result has its own due cycle, counted from the edge that samples the stimulus:
- A read is answered one cycle after the edge that samples it.
- A clear takes effect on its own edge, and its bit reads 1 for exactly one cycle.
- The latch bit reads 1 on the next two sampled edges, and the snapshot is published on the second.

The bench issues its reads on consecutive cycles right after each write, so every poll lands on a known edge. A reference count, advanced on each edge by the requirements, supplies the expected snapshot value. A scoreboard queue pairs each expected word with its requirement, and a monitor compares each word as it returns.

// File: rtl/snap_counter64.sv
module snap_counter64 #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 64,
  parameter int LATCH_CYC = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 8'hA0,
  parameter logic [ADDR_W-1:0] LO_OFF   = 8'hA4,
  parameter logic [ADDR_W-1:0] HI_OFF   = 8'hA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int LEFT_W = $clog2(LATCH_CYC + 1);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(3);

  logic [CNT_W-1:0]  count, hold, snap;
  logic              clr_q, lat_busy;
  logic [LEFT_W-1:0] lat_left;
  logic [DATA_W-1:0] ctrl_bits, rd_mux;

  wire ctrl_wr = bus_wr && (bus_addr == CTRL_OFF);
  assign ctrl_bits = bus_wdata & CTRL_MASK;
  wire clr_req = ctrl_wr && ctrl_bits[0];
  wire lat_req = ctrl_wr && ctrl_bits[1];

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (clr_req) count <= '0;
    else count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) clr_q <= 1'b0;
    else clr_q <= clr_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_busy <= 1'b0;
      lat_left <= '0;
      hold     <= '0;
      snap     <= '0;
    end else if (!lat_busy) begin
      if (lat_req) begin
        lat_busy <= 1'b1;
        lat_left <= LEFT_W'(LATCH_CYC);
      end
    end else begin
      lat_left <= lat_left - 1'b1;
      if (lat_left == LEFT_W'(LATCH_CYC)) hold <= count;
      if (lat_left == LEFT_W'(1)) begin
        snap     <= hold;
        lat_busy <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == CTRL_OFF)    rd_mux = {{(DATA_W-2){1'b0}}, lat_busy, clr_q};
    else if (bus_addr == LO_OFF) rd_mux = snap[DATA_W-1:0];
    else if (bus_addr == HI_OFF) rd_mux = DATA_W'(snap >> DATA_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !clr_q) |=> (count == $past(count) + 1'b1));

  // R5
  clr_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !clr_req) |=> !clr_q);

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> (count == '0));

  // R6
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_busy) |=> lat_busy);

  // R6
  snap_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap) |-> $fell(lat_busy));

  // R4
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R4
  rvalid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

// File: tb/tb_snap_counter64.sv
module tb_snap_counter64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int tests = 0;
  int fails = 0;
  logic [63:0] mcount;
  logic [63:0] exp_snap;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  snap_counter64 dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  // reference count per R2 and R5
  always @(posedge clk) begin
    if (!rst_n) mcount <= '0;
    else if (bus_wr && bus_addr == 8'hA0 && bus_wdata[0]) mcount <= '0;
    else mcount <= mcount + 1;
  end

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4: read data 0x%08h with no read pending, expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: got 0x%08h expected 0x%08h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a; bus_wdata = '0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (bus_rvalid !== 1'b0) begin
      fails++;
      $display("FAIL R4: rvalid %0b during reset, expected 0", bus_rvalid);
    end
    rst_n = 1'b1;
    // R1 reset state
    bus_read(8'hA0, 32'h0, "R1 ctrl");
    bus_read(8'hA4, 32'h0, "R1 low");
    bus_read(8'hA8, 32'h0, "R1 high");

    // R6 R7 R3 plain latch with polling
    bus_write(8'hA0, 32'h2);
    exp_snap = mcount;
    bus_read(8'hA0, 32'h2, "R6 poll E+1");
    bus_read(8'hA0, 32'h2, "R6 poll E+2");
    bus_read(8'hA0, 32'h0, "R7 ctrl restored");
    bus_read(8'hA4, exp_snap[31:0], "R6 low word");
    bus_read(8'hA8, exp_snap[63:32], "R3 high word");

    // R2 count advances one per cycle
    idle(37);
    bus_write(8'hA0, 32'h2);
    exp_snap = mcount;
    bus_read(8'hA0, 32'h2, "R6 poll E+1");
    bus_read(8'hA0, 32'h2, "R6 poll E+2");
    bus_read(8'hA0, 32'h0, "R7 ctrl restored");
    bus_read(8'hA4, exp_snap[31:0], "R2 low after gap");

    // R9 merged request
    bus_write(8'hA0, 32'h2);
    exp_snap = mcount;
    bus_write(8'hA0, 32'h2);
    bus_read(8'hA0, 32'h2, "R9 pending E+2");
    bus_read(8'hA0, 32'h0, "R9 done at E+3");
    bus_read(8'hA4, exp_snap[31:0], "R9 merged value");

    // R5 clear
    idle(5);
    bus_write(8'hA0, 32'h1);
    bus_read(8'hA0, 32'h1, "R5 clr visible");
    bus_read(8'hA0, 32'h0, "R5 clr self-clears");
    bus_write(8'hA0, 32'h2);
    exp_snap = mcount;
    idle(3);
    bus_read(8'hA4, exp_snap[31:0], "R5 count restarted");
    bus_read(8'hA8, exp_snap[63:32], "R5 high zero");

    // R8 both bits
    idle(9);
    bus_write(8'hA0, 32'h3);
    bus_read(8'hA0, 32'h3, "R8 both set");
    bus_read(8'hA0, 32'h2, "R8 clr gone");
    bus_read(8'hA0, 32'h0, "R8 latch done");
    bus_read(8'hA4, 32'h0, "R8 low zero");
    bus_read(8'hA8, 32'h0, "R8 high zero");

    // R10 ignored writes, unmapped reads
    bus_write(8'hA4, 32'hFFFF_FFFF);
    bus_write(8'hA8, 32'hFFFF_FFFF);
    bus_read(8'hA4, 32'h0, "R10 low write ignored");
    bus_read(8'hA8, 32'h0, "R10 high write ignored");
    bus_write(8'hA0, 32'hFFFF_FFFC);
    bus_read(8'hA0, 32'h0, "R10 upper ctrl bits");
    bus_write(8'hA0, 32'h2);
    exp_snap = mcount;
    idle(3);
    bus_read(8'hA4, exp_snap[31:0], "R10 no clear from upper bits");
    bus_read(8'h10, 32'h0, "R10 unmapped 0x10");
    bus_read(8'hAC, 32'h0, "R10 unmapped 0xAC");
    bus_read(8'h00, 32'h0, "R10 unmapped 0x00");

    idle(4);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule